// File: doc/BRIEF.md
# Parallel flash command sequence decoder

This block is the command interpreter on the device side of a byte-wide parallel flash. It watches write cycles from the host bus, each one an address and a data byte presented with a one-cycle write strobe. It recognises the unlock-prefixed command sequences and turns them into operation requests. A byte program or a chip erase leaves the block as a one-cycle start pulse with the target address and data; an external operation timer does the actual work and reports back through a busy input. The memory array and its timing are outside this block.

The decoder also keeps two flags. The first is the identification mode flag. While it is set, reads from the low addresses return the manufacturer code, the device code and the lockout status. The second is a sticky lockout flag that protects a 16K-byte boot region. A parameter places that region at the bottom or at the top of the address space. Once the flag is set, program requests aimed inside the region are dropped, and every erase request carries a qualifier that tells the array to keep the region intact.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all pulse outputs, `lock_flag`, `id_mode` and `id_rdata` are 0, and the sequence tracker is idle.
- R2: The sequence AA@5555h, 55@2AAAh, A0@5555h followed by a fourth write at any address raises `prog_start` for exactly one cycle, in the cycle after the fourth write, with `prog_addr` and `prog_data` taken from that fourth write. A data value of F0h in the fourth write is programmed like any other value.
- R3: Only the low 15 address bits (A14..A0) of a write take part in matching the fixed command addresses. Higher bits are ignored for that purpose.
- R4: The sequence AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 10@5555h raises `erase_start` for one cycle after the sixth write. `erase_keep_boot` is raised in the same cycle exactly when `lock_flag` is set.
- R5: The same six-write sequence ending in 40h@5555h sets `lock_flag` in the cycle after the sixth write. Only reset clears the flag.
- R6: Boot region: addresses 00000h-03FFFh when `BOOT_AT_TOP`=0, and 7C000h-7FFFFh when it is 1. While `lock_flag` is 1, a program request whose target lies in the region produces no `prog_start`. A target at 04000h (bottom variant) is still programmed, and before lockout a target inside the region is programmed.
- R7: AA@5555h, 55@2AAAh, 90@5555h sets `id_mode`. With `id_mode` set, `id_rdata` returns the value for `rd_addr` one cycle later: 1Fh for address 0, the device code for address 1 (13h for bottom boot, 12h for top boot), {7'b0, lock_flag} for address 2, and 00h for any other address. With `id_mode` clear, `id_rdata` is 00h.
- R8: `id_mode` is cleared by the sequence AA@5555h, 55@2AAAh, F0@5555h, or by a single write of F0h to any address, whenever the tracker is not waiting for program data.
- R9: A write that is not the expected next step of a sequence returns the tracker to idle and issues no request. The write that would have followed then has no effect.
- R10: While `busy` is 1, writes are ignored and the tracker keeps its position in the current sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W (19) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| busy | input | 1 | Operation timer busy; writes are ignored while high |
| rd_addr | input | ADDR_W (19) | Read address for identification reads |
| id_rdata | output | DATA_W (8) | Identification read data, registered |
| id_mode | output | 1 | Identification mode flag |
| lock_flag | output | 1 | Sticky boot-region lockout flag |
| prog_start | output | 1 | One-cycle byte program request |
| prog_addr | output | ADDR_W (19) | Target address of the program request |
| prog_data | output | DATA_W (8) | Byte to program |
| erase_start | output | 1 | One-cycle chip erase request |
| erase_keep_boot | output | 1 | With erase_start: keep the boot region intact |

## Verification
The assertions assume that `wr_en` is a single-cycle strobe and that the timer raises `busy` only between whole writes, so the tracker's position can be held across a busy stretch. They also assume that no lockout and no program request are decoded in the same cycle. The one-hot request check and the lockout check both depend on the fact that a single write finishes at most one sequence. The stimulus issues each write as an isolated strobe followed by an idle cycle and changes `busy` only together with a write. It therefore never creates overlapping writes or a busy edge in the middle of a write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PROG,
    SQ_ERA3,
    SQ_ERA4,
    SQ_ERA5
  } seq_t;

  localparam int unsigned CMP_BITS = 15;

  localparam logic [CMP_BITS-1:0] ADR_KEY_P = 15'h5555;
  localparam logic [CMP_BITS-1:0] ADR_KEY_Q = 15'h2AAA;

  localparam logic [7:0] D_KEY_P   = 8'hAA;
  localparam logic [7:0] D_KEY_Q   = 8'h55;
  localparam logic [7:0] D_PROG    = 8'hA0;
  localparam logic [7:0] D_ERASE   = 8'h80;
  localparam logic [7:0] D_ID_IN   = 8'h90;
  localparam logic [7:0] D_ID_OUT  = 8'hF0;
  localparam logic [7:0] D_FIN_ERA = 8'h10;
  localparam logic [7:0] D_FIN_LCK = 8'h40;

endpackage

// File: rtl/flash_boot_guard.sv
module flash_boot_guard #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned BOOT_LOG2 = 14,
  parameter bit          AT_TOP    = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned HI_W = ADDR_W - BOOT_LOG2;

  logic [HI_W-1:0] upper;
  assign upper = addr[ADDR_W-1:BOOT_LOG2];

  generate
    if (AT_TOP) begin : g_top
      assign hit = &upper;
    end else begin : g_bottom
      assign hit = ~|upper;
    end
  endgenerate

  logic [BOOT_LOG2-1:0] unused_low;
  assign unused_low = addr[BOOT_LOG2-1:0];
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned CW = CMP_BITS,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          busy,
  input  logic [CW-1:0] cmp_addr,
  input  logic [DW-1:0] wr_data,
  output logic          fire_prog,
  output logic          fire_erase,
  output logic          fire_lock,
  output logic          fire_idin,
  output logic          fire_idout
);
  seq_t st, nxt;
  logic accept, at_p, at_q;

  assign accept = wr_en && !busy;
  assign at_p   = (cmp_addr == CW'(ADR_KEY_P));
  assign at_q   = (cmp_addr == CW'(ADR_KEY_Q));

  always_comb begin
    nxt        = st;
    fire_prog  = 1'b0;
    fire_erase = 1'b0;
    fire_lock  = 1'b0;
    fire_idin  = 1'b0;
    fire_idout = 1'b0;
    if (accept) begin
      if (st == SQ_PROG) begin
        fire_prog = 1'b1;
        nxt       = SQ_IDLE;
      end else if (wr_data == DW'(D_ID_OUT)) begin
        fire_idout = 1'b1;
        nxt        = SQ_IDLE;
      end else begin
        nxt = SQ_IDLE;
        case (st)
          SQ_IDLE: if (at_p && wr_data == DW'(D_KEY_P)) nxt = SQ_UNL1;
          SQ_UNL1: if (at_q && wr_data == DW'(D_KEY_Q)) nxt = SQ_UNL2;
          SQ_UNL2: begin
            if (at_p) begin
              if (wr_data == DW'(D_PROG))       nxt = SQ_PROG;
              else if (wr_data == DW'(D_ERASE)) nxt = SQ_ERA3;
              else if (wr_data == DW'(D_ID_IN)) fire_idin = 1'b1;
            end
          end
          SQ_ERA3: if (at_p && wr_data == DW'(D_KEY_P)) nxt = SQ_ERA4;
          SQ_ERA4: if (at_q && wr_data == DW'(D_KEY_Q)) nxt = SQ_ERA5;
          SQ_ERA5: begin
            if (at_p && wr_data == DW'(D_FIN_ERA)) fire_erase = 1'b1;
            if (at_p && wr_data == DW'(D_FIN_LCK)) fire_lock  = 1'b1;
          end
          default: nxt = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SQ_IDLE;
    else     st <= nxt;
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(st)); // R10

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fire_prog, fire_erase, fire_lock, fire_idin, fire_idout})); // R9

  AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
    !accept |-> !(fire_prog || fire_erase || fire_lock || fire_idin || fire_idout)); // R10
endmodule

// File: rtl/flash_id_reader.sv
module flash_id_reader #(
  parameter int unsigned    ADDR_W   = 19,
  parameter int unsigned    DW       = 8,
  parameter logic [DW-1:0]  MFR_CODE = 8'h1F,
  parameter logic [DW-1:0]  DEV_CODE = 8'h13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_mode,
  input  logic              lock,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    if (id_mode) begin
      if (rd_addr == ADDR_W'(0))      sel = MFR_CODE;
      else if (rd_addr == ADDR_W'(1)) sel = DEV_CODE;
      else if (rd_addr == ADDR_W'(2)) sel = {{(DW-1){1'b0}}, lock};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end

  AST_ID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !id_mode |=> (rdata == '0)); // R7
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned BOOT_LOG2    = 14,
  parameter bit          BOOT_AT_TOP  = 1'b0,
  parameter logic [7:0]  MFR_ID       = 8'h1F,
  parameter logic [7:0]  DEV_ID_BOT   = 8'h13,
  parameter logic [7:0]  DEV_ID_TOP   = 8'h12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] id_rdata,
  output logic              id_mode,
  output logic              lock_flag,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_start,
  output logic              erase_keep_boot
);
  localparam logic [7:0] DEV_ID = BOOT_AT_TOP ? DEV_ID_TOP : DEV_ID_BOT;

  logic f_prog, f_erase, f_lock, f_idin, f_idout;
  logic wr_in_boot, out_in_boot;

  flash_seq_fsm #(.CW(CMP_BITS), .DW(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy),
    .cmp_addr(wr_addr[CMP_BITS-1:0]), .wr_data(wr_data),
    .fire_prog(f_prog), .fire_erase(f_erase), .fire_lock(f_lock),
    .fire_idin(f_idin), .fire_idout(f_idout)
  );

  flash_boot_guard #(.ADDR_W(ADDR_W), .BOOT_LOG2(BOOT_LOG2), .AT_TOP(BOOT_AT_TOP)) u_wr_guard (
    .addr(wr_addr), .hit(wr_in_boot)
  );

  flash_id_reader #(.ADDR_W(ADDR_W), .DW(DATA_W), .MFR_CODE(DATA_W'(MFR_ID)),
                    .DEV_CODE(DATA_W'(DEV_ID))) u_id (
    .clk(clk), .rst(rst), .id_mode(id_mode), .lock(lock_flag),
    .rd_addr(rd_addr), .rdata(id_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_flag       <= 1'b0;
      id_mode         <= 1'b0;
      prog_start      <= 1'b0;
      prog_addr       <= '0;
      prog_data       <= '0;
      erase_start     <= 1'b0;
      erase_keep_boot <= 1'b0;
    end else begin
      prog_start      <= 1'b0;
      erase_start     <= f_erase;
      erase_keep_boot <= f_erase && lock_flag;
      if (f_lock)  lock_flag <= 1'b1;
      if (f_idin)  id_mode   <= 1'b1;
      if (f_idout) id_mode   <= 1'b0;
      if (f_prog && !(lock_flag && wr_in_boot)) begin
        prog_start <= 1'b1;
        prog_addr  <= wr_addr;
        prog_data  <= wr_data;
      end
    end
  end

  flash_boot_guard #(.ADDR_W(ADDR_W), .BOOT_LOG2(BOOT_LOG2), .AT_TOP(BOOT_AT_TOP)) u_out_guard (
    .addr(prog_addr), .hit(out_in_boot)
  );

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock_flag |=> lock_flag); // R5

  AST_BOOT_SAFE: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> !(lock_flag && out_in_boot)); // R6

  AST_PROG_PULSE: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start); // R2

  AST_ERASE_KEEP: assert property (@(posedge clk) disable iff (rst)
    erase_keep_boot |-> (erase_start && lock_flag)); // R4

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(prog_start && erase_start)); // R9
endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [18:0] rd_addr = '0;
  logic [7:0]  id_rdata;
  logic        id_mode, lock_flag, prog_start, erase_start, erase_keep_boot;
  logic [18:0] prog_addr;
  logic [7:0]  prog_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .id_rdata(id_rdata), .id_mode(id_mode),
    .lock_flag(lock_flag), .prog_start(prog_start), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_start(erase_start), .erase_keep_boot(erase_keep_boot)
  );

  // row: {req[3:0], expect{prog,erase,keep,lock,id}[4:0], busy, addr[19:0], data[7:0]}
  localparam int NV = 63;
  localparam logic [37:0] TBL [0:NV-1] = '{
    {4'd3, 5'h00, 1'b0, 20'h7D555, 8'hAA},  // R3 high bits set
    {4'd3, 5'h00, 1'b0, 20'h4AAAA, 8'h55},
    {4'd3, 5'h00, 1'b0, 20'h35555, 8'hA0},
    {4'd2, 5'h10, 1'b0, 20'h12345, 8'h3C},  // R2 program pulse
    {4'd6, 5'h00, 1'b0, 20'h05555, 8'hAA},  // R6 boot programmable before lock
    {4'd6, 5'h00, 1'b0, 20'h02AAA, 8'h55},
    {4'd6, 5'h00, 1'b0, 20'h05555, 8'hA0},
    {4'd6, 5'h10, 1'b0, 20'h00100, 8'h81},
    {4'd4, 5'h00, 1'b0, 20'h05555, 8'hAA},  // R4 erase
    {4'd4, 5'h00, 1'b0, 20'h02AAA, 8'h55},
    {4'd4, 5'h00, 1'b0, 20'h05555, 8'h80},
    {4'd4, 5'h00, 1'b0, 20'h05555, 8'hAA},
    {4'd4, 5'h00, 1'b0, 20'h02AAA, 8'h55},
    {4'd4, 5'h08, 1'b0, 20'h05555, 8'h10},
    {4'd9, 5'h00, 1'b0, 20'h05555, 8'hAA},  // R9 bad command byte
    {4'd9, 5'h00, 1'b0, 20'h02AAA, 8'h55},
    {4'd9, 5'h00, 1'b0, 20'h05555, 8'h77},
    {4'd9, 5'h00, 1'b0, 20'h00200, 8'h22},
    {4'd9, 5'h00, 1'b0, 20'h05555, 8'hAA},  // R9 bad unlock address
    {4'd9, 5'h00, 1'b0, 20'h01234, 8'h55},
    {4'd9, 5'h00, 1'b0, 20'h05555, 8'hA0},
    {4'd9, 5'h00, 1'b0, 20'h00300, 8'h33},
    {4'd10, 5'h00, 1'b0, 20'h05555, 8'hAA}, // R10 busy holds position
    {4'd10, 5'h00, 1'b1, 20'h00000, 8'h99},
    {4'd10, 5'h00, 1'b0, 20'h02AAA, 8'h55},
    {4'd10, 5'h00, 1'b0, 20'h05555, 8'hA0},
    {4'd10, 5'h10, 1'b0, 20'h40000, 8'h44},
    {4'd10, 5'h00, 1'b1, 20'h05555, 8'hAA}, // R10 whole sequence while busy
    {4'd10, 5'h00, 1'b1, 20'h02AAA, 8'h55},
    {4'd10, 5'h00, 1'b1, 20'h05555, 8'hA0},
    {4'd10, 5'h00, 1'b1, 20'h00400, 8'h11},
    {4'd7, 5'h00, 1'b0, 20'h05555, 8'hAA},  // R7 id entry
    {4'd7, 5'h00, 1'b0, 20'h02AAA, 8'h55},
    {4'd7, 5'h01, 1'b0, 20'h05555, 8'h90},
    {4'd8, 5'h00, 1'b0, 20'h01234, 8'hF0},  // R8 single F0 exit
    {4'd7, 5'h00, 1'b0, 20'h05555, 8'hAA},
    {4'd7, 5'h00, 1'b0, 20'h02AAA, 8'h55},
    {4'd7, 5'h01, 1'b0, 20'h05555, 8'h90},
    {4'd8, 5'h01, 1'b0, 20'h05555, 8'hAA},  // R8 unlocked exit
    {4'd8, 5'h01, 1'b0, 20'h02AAA, 8'h55},
    {4'd8, 5'h00, 1'b0, 20'h05555, 8'hF0},
    {4'd5, 5'h00, 1'b0, 20'h05555, 8'hAA},  // R5 lockout
    {4'd5, 5'h00, 1'b0, 20'h02AAA, 8'h55},
    {4'd5, 5'h00, 1'b0, 20'h05555, 8'h80},
    {4'd5, 5'h00, 1'b0, 20'h05555, 8'hAA},
    {4'd5, 5'h00, 1'b0, 20'h02AAA, 8'h55},
    {4'd5, 5'h02, 1'b0, 20'h05555, 8'h40},
    {4'd6, 5'h02, 1'b0, 20'h05555, 8'hAA},  // R6 boot target dropped
    {4'd6, 5'h02, 1'b0, 20'h02AAA, 8'h55},
    {4'd6, 5'h02, 1'b0, 20'h05555, 8'hA0},
    {4'd6, 5'h02, 1'b0, 20'h01000, 8'h55},
    {4'd6, 5'h02, 1'b0, 20'h05555, 8'hAA},  // R6 first address past region
    {4'd6, 5'h02, 1'b0, 20'h02AAA, 8'h55},
    {4'd6, 5'h02, 1'b0, 20'h05555, 8'hA0},
    {4'd6, 5'h12, 1'b0, 20'h04000, 8'h66},
    {4'd6, 5'h02, 1'b0, 20'h05555, 8'hAA},  // R6 last address of region
    {4'd6, 5'h02, 1'b0, 20'h02AAA, 8'h55},
    {4'd6, 5'h02, 1'b0, 20'h05555, 8'hA0},
    {4'd6, 5'h02, 1'b0, 20'h03FFF, 8'h77},
    {4'd8, 5'h02, 1'b0, 20'h05555, 8'hAA},  // R8 F0 as program data
    {4'd8, 5'h02, 1'b0, 20'h02AAA, 8'h55},
    {4'd8, 5'h02, 1'b0, 20'h05555, 8'hA0},
    {4'd2, 5'h12, 1'b0, 20'h05000, 8'hF0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; busy = b; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic rd(input logic [18:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(req, {24'h0, id_rdata}, {24'h0, exp});
  endtask

  task automatic seq3(input logic [7:0] cmd);
    wr(1'b0, 19'h05555, 8'hAA);
    wr(1'b0, 19'h02AAA, 8'h55);
    wr(1'b0, 19'h05555, cmd);
  endtask

  task automatic seq6(input logic [7:0] fin);
    seq3(8'h80);
    wr(1'b0, 19'h05555, 8'hAA);
    wr(1'b0, 19'h02AAA, 8'h55);
    wr(1'b0, 19'h05555, fin);
  endtask

  function automatic logic [31:0] flags();
    return {27'h0, prog_start, erase_start, erase_keep_boot, lock_flag, id_mode};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flags", flags(), 32'h0);
    chk("R1 id_rdata", {24'h0, id_rdata}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] e;
      e = TBL[i];
      wr(e[28], e[26:8], e[7:0]);
      chk($sformatf("R%0d row %0d", e[37:34], i), flags(), {27'h0, e[33:29]});
      if (e[33]) begin
        chk($sformatf("R%0d row %0d addr", e[37:34], i), {13'h0, prog_addr}, {13'h0, e[26:8]});
        chk($sformatf("R%0d row %0d data", e[37:34], i), {24'h0, prog_data}, {24'h0, e[7:0]});
      end
    end

    // R7 identification reads while locked
    seq3(8'h90);
    chk("R7 id entry", {31'h0, id_mode}, 32'h1);
    rd(19'h00000, 8'h1F, "R7 mfr");
    rd(19'h00001, 8'h13, "R7 dev");
    rd(19'h00002, 8'h01, "R7 lock bit");
    rd(19'h00003, 8'h00, "R7 other");
    rd(19'h40000, 8'h00, "R7 high addr");
    wr(1'b0, 19'h00007, 8'hF0);
    chk("R8 exit", {31'h0, id_mode}, 32'h0);
    rd(19'h00000, 8'h00, "R7 quiet outside id");

    // R4 erase after lockout keeps boot region
    seq6(8'h10);
    chk("R4 erase keep", flags(), 32'h0E);
    @(negedge clk);
    chk("R4 erase pulse ends", flags(), 32'h02);

    // R5 lockout stays set
    seq6(8'h40);
    wr(1'b0, 19'h05555, 8'hF0);
    chk("R5 sticky", {31'h0, lock_flag}, 32'h1);

    // R1 reset clears everything
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flags after reset", flags(), 32'h0);
    seq3(8'h90);
    rd(19'h00002, 8'h00, "R7 unlocked bit");
    rd(19'h00001, 8'h13, "R7 dev after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule